// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the processor-facing side of a byte-oriented I2C master. It decodes four 16-bit registers that sit on halfword offsets. They hold a global enable, a control/status word, one 8-bit data field and the interrupt enables. The block also tracks two interrupt causes, transmit-buffer-empty and receive-buffer-full, and drives one level interrupt request. Bus timing, START/STOP, acknowledge handling and clock stretching belong to a separate bit-level shift engine. This block exchanges whole bytes with that engine: a valid/ready pair hands a transmit byte over, and a one-cycle strobe delivers a received byte.

Both directions share the one data field. A write from the processor replaces any received byte that has not been read yet. Each interrupt cause is cleared only by an access to the data register: a write clears the transmit cause and a read clears the receive cause. There is no write-one-to-clear status bit.

Register map (byte address, bit 0 of the address ignored): 0x0 enable, 0x2 control/status, 0x4 data, 0x6 interrupt control. Reads are combinational from the address. A cycle with both write and read strobes counts as a write only.

Top module: `i2c_host_regif`

## Requirements
- R1: After synchronous reset, every register reads 0x0000, `irq` is 0 and `tx_valid` is 0.
- R2: Enable register bit 0 is the peripheral enable, readable and writable. Reserved bits read 0 in every register and ignore writes: enable keeps bit 0, control keeps bit 0 writable, interrupt control keeps bits 1:0, and data keeps bits 7:0.
- R3: When a data write happens while enable=1 and control bit 0 (transmit enable)=1, `tx_valid` is 1 from the next cycle on and `tx_byte` carries the written byte. Both hold steady until a cycle with `tx_ready`=1. Control bit 1 mirrors `tx_valid`.
- R4: A data write while transmit enable or peripheral enable is 0 still stores the byte in the data field, but it raises no `tx_valid`.
- R5: The transmit-empty flag (control bit 2) is set in the cycle after a cycle with `tx_valid`=1 and `tx_ready`=1. It is cleared by a data write.
- R6: While enabled, a cycle with `rx_valid`=1 stores `rx_byte` in the data field and sets the receive-full flag (control bit 3) at the same clock edge.
- R7: A data read clears receive-full, unless a new byte arrives in the same cycle.
- R8: A data write overwrites an unread received byte. It does not clear receive-full.
- R9: `irq` is the level OR of (transmit-empty AND interrupt control bit 0) and (receive-full AND interrupt control bit 1). It holds until the enabled causes are cleared, and it rises as soon as an enable bit is set on a cause that is already pending.
- R10: Writing enable=0 drops `tx_valid`, clears both flags and forces `irq` low. While disabled, `rx_valid` is ignored. The data field, transmit enable and interrupt enables are kept.
- R11: When a data write and `rx_valid` fall in the same cycle, the written byte wins and the received byte is discarded without setting receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on data register) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Level interrupt request |
| tx_valid | output | 1 | Transmit byte offered to shift engine |
| tx_ready | input | 1 | Shift engine accepts the transmit byte |
| tx_byte | output | BYTE_W | Transmit byte |
| rx_valid | input | 1 | One-cycle strobe: received byte present |
| rx_byte | input | BYTE_W | Received byte |

## Verification
The assertions assume that the shift engine pulses `rx_valid` for one cycle per byte. They also assume that `tx_ready` matters only while `tx_valid` is high, and that the bus never presents a write and a read together. The stimulus drives every bus access and every engine strobe as a single-cycle pulse between falling edges, so it stays inside these assumptions. The only deliberate overlap is the single collision of a data write with `rx_valid` that R11 describes. Transmit and receive data paths are swept over all 256 byte values.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SLOT_EN   = 2'd0,
        SLOT_CTRL = 2'd1,
        SLOT_DATA = 2'd2,
        SLOT_ICTL = 2'd3
    } slot_e;

    localparam int CTRL_TXEN_BIT  = 0;
    localparam int CTRL_TXPEND_BIT = 1;
    localparam int CTRL_TXMT_BIT  = 2;
    localparam int CTRL_RXFULL_BIT = 3;
    localparam int ICTL_TXIE_BIT  = 0;
    localparam int ICTL_RXIE_BIT  = 1;

    typedef struct packed {
        logic tx_en;
        logic tx_ie;
        logic rx_ie;
    } cfg_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        slot_e            slot;
        logic [REG_W-1:0] wdata;
    } bus_req_t;

    function automatic slot_e slot_of(input logic [1:0] halfword);
        return slot_e'(halfword);
    endfunction

endpackage

// File: rtl/i2c_host_cfg.sv
module i2c_host_cfg
    import i2c_host_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     en_q,
    output logic     en_nxt,
    output cfg_t     cfg
);

    logic en_wr, ctrl_wr, ictl_wr;

    assign en_wr   = req.wr && (req.slot == SLOT_EN);
    assign ctrl_wr = req.wr && (req.slot == SLOT_CTRL);
    assign ictl_wr = req.wr && (req.slot == SLOT_ICTL);
    assign en_nxt  = en_wr ? req.wdata[0] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            cfg  <= '0;
        end else begin
            en_q <= en_nxt;
            if (ctrl_wr)
                cfg.tx_en <= req.wdata[CTRL_TXEN_BIT];
            if (ictl_wr) begin
                cfg.tx_ie <= req.wdata[ICTL_TXIE_BIT];
                cfg.rx_ie <= req.wdata[ICTL_RXIE_BIT];
            end
        end
    end

    // R2: enable follows bit 0 of a write, other bits have no effect
    assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(req.wdata[0])));

endmodule

// File: rtl/i2c_host_tx.sv
module i2c_host_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              launch_ok,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_empty
);

    logic accept;
    assign accept = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            tx_empty <= 1'b0;
        end else if (clr) begin
            tx_valid <= 1'b0;
            tx_empty <= 1'b0;
        end else begin
            if (data_wr && launch_ok) begin
                tx_valid <= 1'b1;
                tx_byte  <= wbyte;
            end else if (accept) begin
                tx_valid <= 1'b0;
            end
            if (data_wr)
                tx_empty <= 1'b0;
            else if (accept)
                tx_empty <= 1'b1;
        end
    end

    assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && launch_ok && !clr) |=> (tx_valid && tx_byte == $past(wbyte)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !data_wr && !clr) |=> (tx_valid && $stable(tx_byte)));

    assert_no_launch_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && data_wr && !launch_ok) |=> !tx_valid);

    assert_empty_set_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !data_wr && !clr) |=> tx_empty);

endmodule

// File: rtl/i2c_host_rx.sv
module i2c_host_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take_ok,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] data_q,
    output logic              rx_full
);

    logic take;
    assign take = rx_valid && take_ok && !data_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            rx_full <= 1'b0;
        end else begin
            if (data_wr)
                data_q <= wbyte;
            else if (take)
                data_q <= rx_byte;
            if (clr)
                rx_full <= 1'b0;
            else if (take)
                rx_full <= 1'b1;
            else if (data_rd)
                rx_full <= 1'b0;
        end
    end

    assert_rx_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && take_ok && !data_wr && !clr) |=> (rx_full && data_q == $past(rx_byte)));

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_valid) |=> !rx_full);

    assert_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && rx_full && !clr) |=> (rx_full && data_q == $past(wbyte)));

    assert_collide_R11: assert property (@(posedge clk) disable iff (rst)
        (data_wr && rx_valid && !rx_full) |=> !rx_full);

endmodule

// File: rtl/i2c_host_regif.sv
module i2c_host_regif
    import i2c_host_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte
);

    localparam int PAD_W = REG_W - BYTE_W;

    bus_req_t          req;
    cfg_t              cfg;
    logic              en_q, en_nxt, clr;
    logic              data_wr, data_rd;
    logic              tx_empty, rx_full;
    logic [BYTE_W-1:0] data_q;

    always_comb begin
        req.wr    = bus_sel && bus_wr;
        req.rd    = bus_sel && bus_rd && !bus_wr;
        req.slot  = slot_of(bus_addr[2:1]);
        req.wdata = bus_wdata;
    end

    assign data_wr = req.wr && (req.slot == SLOT_DATA);
    assign data_rd = req.rd && (req.slot == SLOT_DATA);
    assign clr     = !en_nxt;

    i2c_host_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .en_q   (en_q),
        .en_nxt (en_nxt),
        .cfg    (cfg)
    );

    i2c_host_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .data_wr   (data_wr),
        .wbyte     (bus_wdata[BYTE_W-1:0]),
        .launch_ok (en_q && cfg.tx_en),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_empty  (tx_empty)
    );

    i2c_host_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .take_ok  (en_q),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .data_q   (data_q),
        .rx_full  (rx_full)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (req.slot)
            SLOT_EN:   bus_rdata[0] = en_q;
            SLOT_CTRL: begin
                bus_rdata[CTRL_TXEN_BIT]   = cfg.tx_en;
                bus_rdata[CTRL_TXPEND_BIT] = tx_valid;
                bus_rdata[CTRL_TXMT_BIT]   = tx_empty;
                bus_rdata[CTRL_RXFULL_BIT] = rx_full;
            end
            SLOT_DATA: bus_rdata = {{PAD_W{1'b0}}, data_q};
            SLOT_ICTL: begin
                bus_rdata[ICTL_TXIE_BIT] = cfg.tx_ie;
                bus_rdata[ICTL_RXIE_BIT] = cfg.rx_ie;
            end
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (tx_empty && cfg.tx_ie) || (rx_full && cfg.rx_ie);

    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!irq && !tx_valid));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req.slot == SLOT_EN) |-> (bus_rdata[REG_W-1:1] == '0));

    assert_ignore_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !en_nxt && rx_valid && !data_wr) |=> $stable(data_q));

endmodule

// File: tb/tb_i2c_host_regif.sv
module tb_i2c_host_regif;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] rd;

    localparam logic [2:0] A_EN = 3'h0, A_CTRL = 3'h2, A_DATA = 3'h4, A_ICTL = 3'h6;

    always #2.5 clk = ~clk;

    i2c_host_regif dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            bread(3'(2 * i), rd);
            chk("R1 reg reset", rd, 16'h0000);
        end
        chk("R1 irq reset", {15'b0, irq}, 16'h0);
        chk("R1 tx_valid reset", {15'b0, tx_valid}, 16'h0);

        // R4 with peripheral disabled, then R2 reserved bits
        bwrite(A_DATA, 16'hFFFF);
        chk("R4 no launch while off", {15'b0, tx_valid}, 16'h0);
        bread(A_DATA, rd);  chk("R2 data mask", rd, 16'h00FF);
        bwrite(A_EN, 16'hFFFF);
        bread(A_EN, rd);    chk("R2 enable mask", rd, 16'h0001);
        bwrite(A_CTRL, 16'hFFF0);
        bread(A_CTRL, rd);  chk("R2 ctrl ro bits", rd, 16'h0000);
        bwrite(A_CTRL, 16'hFFFF);
        bread(A_CTRL, rd);  chk("R2 ctrl mask", rd, 16'h0001);
        bwrite(A_ICTL, 16'hFFFF);
        bread(A_ICTL, rd);  chk("R2 ictl mask", rd, 16'h0003);
        for (int v = 0; v < 4; v++) begin
            bwrite(A_EN, 16'(v) | 16'hFFFE);
            bread(A_EN, rd);  chk("R2 enable sweep", rd, 16'(v & 1));
        end
        bwrite(A_ICTL, 16'h0001);

        // R3 / R5 / R9 transmit sweep
        for (int b = 0; b < 256; b++) begin
            bwrite(A_DATA, 16'(b));
            chk("R3 tx_valid", {15'b0, tx_valid}, 16'h1);
            chk("R3 tx_byte", {8'b0, tx_byte}, 16'(b));
            chk("R9 irq cleared by write", {15'b0, irq}, 16'h0);
            @(negedge clk);
            chk("R3 hold", {7'b0, tx_valid, tx_byte}, 16'h100 | 16'(b));
            tx_take();
            chk("R3 drop after accept", {15'b0, tx_valid}, 16'h0);
            bread(A_CTRL, rd); chk("R5 empty flag", rd, 16'h0005);
            chk("R9 tx irq", {15'b0, irq}, 16'h1);
        end

        // R4 transmit enable off
        bwrite(A_CTRL, 16'h0000);
        bwrite(A_DATA, 16'h005A);
        chk("R4 no launch tx_en=0", {15'b0, tx_valid}, 16'h0);
        bread(A_DATA, rd); chk("R4 data stored", rd, 16'h005A);
        bread(A_CTRL, rd); chk("R5 empty cleared by write", rd, 16'h0000);

        // R6 / R7 / R9 receive sweep
        bwrite(A_ICTL, 16'h0002);
        for (int b = 0; b < 256; b++) begin
            rx_push(8'(255 - b));
            chk("R6 rx irq", {15'b0, irq}, 16'h1);
            bread(A_CTRL, rd); chk("R6 full flag", rd, 16'h0008);
            bread(A_DATA, rd); chk("R6 rx byte", rd, 16'(255 - b));
            chk("R7 irq after read", {15'b0, irq}, 16'h0);
            bread(A_CTRL, rd); chk("R7 full cleared", rd, 16'h0000);
        end

        // R9 enable gating and level behaviour
        bwrite(A_ICTL, 16'h0000);
        rx_push(8'h3C);
        chk("R9 masked cause", {15'b0, irq}, 16'h0);
        bread(A_CTRL, rd); chk("R9 cause pending", rd, 16'h0008);
        repeat (4) @(negedge clk);
        bwrite(A_ICTL, 16'h0002);
        chk("R9 late enable", {15'b0, irq}, 16'h1);
        repeat (4) @(negedge clk);
        chk("R9 level held", {15'b0, irq}, 16'h1);
        bread(A_DATA, rd); chk("R9 clear by read", {15'b0, irq}, 16'h0);

        // R8 overwrite of unread byte
        rx_push(8'h33);
        bwrite(A_DATA, 16'h00C4);
        bread(A_CTRL, rd); chk("R8 full kept", rd, 16'h0008);
        bread(A_DATA, rd); chk("R8 overwrite", rd, 16'h00C4);

        // R11 write collides with received byte
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 16'h0011;
        rx_valid = 1'b1; rx_byte = 8'h99;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        bread(A_CTRL, rd); chk("R11 no full", rd, 16'h0000);
        bread(A_DATA, rd); chk("R11 write wins", rd, 16'h0011);

        // R10 disable
        bwrite(A_CTRL, 16'h0001);
        bwrite(A_DATA, 16'h0077);
        rx_push(8'h42);
        chk("R10 pre irq", {15'b0, irq}, 16'h1);
        bwrite(A_EN, 16'h0000);
        chk("R10 tx_valid dropped", {15'b0, tx_valid}, 16'h0);
        chk("R10 irq low", {15'b0, irq}, 16'h0);
        bread(A_CTRL, rd); chk("R10 flags cleared", rd, 16'h0001);
        bread(A_ICTL, rd); chk("R10 ictl kept", rd, 16'h0002);
        rx_push(8'h10);
        bread(A_DATA, rd); chk("R10 rx ignored", rd, 16'h0042);
        bread(A_CTRL, rd); chk("R10 no full while off", rd, 16'h0001);
        bread(A_EN, rd);   chk("R10 enable off", rd, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule